// File: doc/BRIEF.md
# Looping Pulse-Train Sequencer

This block plays a waveform stored as a list of 16-bit entries in a small local memory. Each entry gives one output level and how many ticks that level lasts. A tick is one period of a programmable divider on the system clock. Each entry is laid out as follows:

- bit 15 is the level;
- bits 14:0 are the duration in ticks;
- a duration of zero marks the end of the list.

The sequencer fetches the entries one at a time through a read port with one cycle of latency. It drives each level for its duration. At the terminator it either finishes (one-shot) or jumps back to address 0 (repeat mode).

In repeat mode an optional loop counter bounds the number of passes. When the last pass ends, the block reports both a loop event and an end event. A separate mark event fires when the number of entries played since the start reaches a programmed value. A stop command aborts playback at any time. While idle, the output shows a programmable rest level, and the output enable follows a programmable rest-drive bit.

Top module: `pulse_seq`

## Requirements
- R1: After synchronous reset the following hold:
  - `seq_state` is 0 and `mem_ren` is 0;
  - all three event outputs are 0;
  - `pulse_out` equals `rest_level` and `pulse_oe` equals `rest_drive`.
- R2: A `run_start` pulse in idle begins playback at address 0. `seq_state` codes are 0 idle, 1 read (with `mem_ren` high), 2 capture and 3 send. The first read is in the cycle after the start edge. Each nonzero entry occupies 2 fetch cycles plus duration x divider cycles. During send, `pulse_out` is bit 15 of the entry and `pulse_oe` is 1.
- R3: A `tick_div` of 0 or 1 both give one tick per clock. A value N above 1 gives one tick every N clocks.
- R4: In one-shot mode (`repeat_en` = 0), an entry whose duration is zero ends playback. `done_evt` pulses for one cycle, two cycles after that entry's read starts, and the block returns to idle.
- R5: In repeat mode with `loop_count_en` = 0, the terminator sends playback back to address 0 indefinitely. No end event occurs.
- R6: In repeat mode with `loop_count_en` = 1, each terminator advances a pass counter. When the counter reaches a nonzero `loop_target`:
  - `loops_evt` and `done_evt` pulse in the same cycle;
  - the block goes idle;
  - the counter returns to 0.
- R7: A `loop_count_clr` pulse zeroes the pass counter, so further passes count from zero.
- R8: The number of entries played is zeroed at each start. `mark_evt` pulses once, in the cycle after the entry that brings this count to a nonzero `entry_mark` completes. Terminators do not count. A mark of 0, or a mark above the total played, never fires.
- R9: `run_stop` sends the block to idle at the next edge with no end event. Stop wins over a terminator decoded at the same edge.
- R10: `run_start` while playback is busy is ignored, and the run's timing is unchanged.
- R11: In idle, `pulse_out` is `rest_level` and `pulse_oe` is `rest_drive`. Both follow those inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start pulse, taken in idle only |
| run_stop | input | 1 | Abort pulse |
| repeat_en | input | 1 | 1: restart at address 0 after the terminator |
| loop_count_en | input | 1 | Enable the pass counter in repeat mode |
| loop_target | input | 10 | Number of passes; 0 means unbounded |
| loop_count_clr | input | 1 | Zero the pass counter |
| entry_mark | input | 9 | Played-entry count that raises the mark event |
| tick_div | input | 8 | Clock cycles per duration tick |
| rest_level | input | 1 | Output level in idle |
| rest_drive | input | 1 | Output enable in idle |
| mem_rdata | input | 16 | Entry data, valid the cycle after `mem_ren` |
| mem_ren | output | 1 | Entry read strobe |
| mem_raddr | output | 4 | Entry read address |
| pulse_out | output | 1 | Waveform |
| pulse_oe | output | 1 | Waveform output enable |
| seq_state | output | 3 | Sequencer state code |
| done_evt | output | 1 | End-of-playback pulse |
| mark_evt | output | 1 | Entry-mark pulse |
| loops_evt | output | 1 | Final-pass pulse |

## Verification
Two functions can collide in one cycle: a stop command and the decode of a terminator. The bench derives, from the entry timing rule, the exact edge at which the terminator is captured, and it raises `run_stop` for that edge alone. The check passes only if `done_evt` never rises and the state code is idle afterwards. The pass counter shows a second planned coincidence: the bench requires `loops_evt` and `done_evt` to appear in the same cycle, at the edge computed from the pass length.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

    localparam int ENTRY_W = 16;
    localparam int DUR_W   = ENTRY_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_SEND    = 3'd3
    } seq_state_e;

    typedef struct packed {
        logic             level;
        logic [DUR_W-1:0] dur;
    } entry_t;

    function automatic entry_t unpack_entry(input logic [ENTRY_W-1:0] word);
        return entry_t'(word);
    endfunction

    function automatic logic is_terminator(input entry_t e);
        return (e.dur == '0);
    endfunction

endpackage

// File: rtl/pulse_seq_tick.sv
module pulse_seq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             last;

    // Divider values 0 and 1 both mean a tick on every clock.
    assign last = (div <= DIV_W'(1)) || (cnt_q == div - DIV_W'(1));
    assign tick = run && last;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/pulse_seq_loopctr.sv
module pulse_seq_loopctr #(
    parameter int LOOP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bump,
    input  logic              en,
    input  logic [LOOP_W-1:0] target,
    output logic              done
);
    logic [LOOP_W-1:0] cnt_q;
    logic [LOOP_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + LOOP_W'(1);
    assign done   = bump && en && (target != '0) && (cnt_nx == target);

    always_ff @(posedge clk) begin
        if (rst || clr || done)
            cnt_q <= '0;
        else if (bump && en)
            cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/pulse_seq_markctr.sv
module pulse_seq_markctr #(
    parameter int MARK_W = 9,
    parameter int CNT_W  = MARK_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bump,
    input  logic [MARK_W-1:0] mark,
    output logic              hit
);
    logic [CNT_W-1:0] cnt_q;

    assign hit = bump && (mark != '0) && ((cnt_q + CNT_W'(1)) == CNT_W'(mark));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import pulse_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 8,
    parameter int LOOP_W = 10,
    parameter int MARK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    input  logic              run_stop,
    input  logic              repeat_en,
    input  logic              loop_count_en,
    input  logic [LOOP_W-1:0] loop_target,
    input  logic              loop_count_clr,
    input  logic [MARK_W-1:0] entry_mark,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic              rest_level,
    input  logic              rest_drive,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic              mem_ren,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              pulse_out,
    output logic              pulse_oe,
    output logic [2:0]        seq_state,
    output logic              done_evt,
    output logic              mark_evt,
    output logic              loops_evt
);
    localparam int CNT_W = MARK_W + 1;

    seq_state_e       state_q, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DUR_W-1:0]  dur_q;
    logic              level_q;
    entry_t            entry;
    logic              term;
    logic              accept;
    logic              tick;
    logic              loop_bump;
    logic              loop_done;
    logic              oneshot_end;
    logic              entry_done;
    logic              mark_hit;

    assign entry       = unpack_entry(mem_rdata);
    assign term        = is_terminator(entry);
    assign accept      = (state_q == ST_IDLE) && run_start && !run_stop;
    assign loop_bump   = (state_q == ST_CAPTURE) && term && repeat_en && !run_stop;
    assign oneshot_end = (state_q == ST_CAPTURE) && term && !repeat_en && !run_stop;
    assign entry_done  = (state_q == ST_SEND) && tick && (dur_q == DUR_W'(1)) && !run_stop;

    pulse_seq_tick #(.DIV_W(DIV_W)) tick_i (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q == ST_CAPTURE),
        .run   (state_q == ST_SEND),
        .div   (tick_div),
        .tick  (tick)
    );

    pulse_seq_loopctr #(.LOOP_W(LOOP_W)) loop_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (loop_count_clr),
        .bump   (loop_bump),
        .en     (loop_count_en),
        .target (loop_target),
        .done   (loop_done)
    );

    pulse_seq_markctr #(.MARK_W(MARK_W), .CNT_W(CNT_W)) mark_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .bump (entry_done),
        .mark (entry_mark),
        .hit  (mark_hit)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_nx = ST_READ;
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: begin
                if (!term)
                    state_nx = ST_SEND;
                else if (repeat_en && !loop_done)
                    state_nx = ST_READ;
                else
                    state_nx = ST_IDLE;
            end
            ST_SEND:    if (entry_done) state_nx = ST_READ;
            default:    state_nx = ST_IDLE;
        endcase
        if (run_stop)
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            dur_q     <= '0;
            level_q   <= 1'b0;
            done_evt  <= 1'b0;
            mark_evt  <= 1'b0;
            loops_evt <= 1'b0;
        end else begin
            state_q   <= state_nx;
            done_evt  <= oneshot_end || loop_done;
            mark_evt  <= mark_hit;
            loops_evt <= loop_done;
            if (accept) begin
                addr_q  <= '0;
                level_q <= rest_level;
            end
            if ((state_q == ST_CAPTURE) && !term) begin
                level_q <= entry.level;
                dur_q   <= entry.dur;
            end
            if (loop_bump)
                addr_q <= '0;
            if (entry_done)
                addr_q <= addr_q + ADDR_W'(1);
            else if ((state_q == ST_SEND) && tick)
                dur_q <= dur_q - DUR_W'(1);
        end
    end

    assign mem_ren   = (state_q == ST_READ);
    assign mem_raddr = addr_q;
    assign pulse_out = (state_q == ST_IDLE) ? rest_level : level_q;
    assign pulse_oe  = (state_q == ST_IDLE) ? rest_drive : 1'b1;
    assign seq_state = state_q;
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_stop,
    input logic       mem_ren,
    input logic [2:0] seq_state,
    input logic       done_evt,
    input logic       mark_evt,
    input logic       loops_evt
);
    assert_loops_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        loops_evt |-> done_evt);

    assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
        run_stop |=> (seq_state == 3'd0));

    assert_done_in_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (seq_state == 3'd0));

    assert_read_then_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_ren && !run_stop) |=> (seq_state == 3'd2));

    assert_mark_after_send_R8: assert property (@(posedge clk) disable iff (rst)
        mark_evt |-> ($past(seq_state) == 3'd3));

    assert_state_legal_R2: assert property (@(posedge clk) disable iff (rst)
        seq_state <= 3'd3);
endmodule

bind pulse_seq pulse_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_stop  (run_stop),
    .mem_ren   (mem_ren),
    .seq_state (seq_state),
    .done_evt  (done_evt),
    .mark_evt  (mark_evt),
    .loops_evt (loops_evt)
);

// File: tb/pulse_seq_tb_top.sv
module pulse_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 7;
    // row: divider, d0, d1, d2, mark, repeat, loop target
    localparam int VEC [0:NROWS-1][0:6] = '{
        '{1, 3, 5, 2, 2, 0, 0},
        '{3, 1, 2, 0, 1, 0, 0},
        '{0, 4, 0, 0, 0, 0, 0},
        '{2, 2, 1, 0, 3, 1, 2},
        '{1, 1, 1, 1, 9, 0, 0},
        '{1, 2, 0, 0, 2, 1, 3},
        '{1, 0, 0, 0, 1, 0, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_start = 1'b0, run_stop = 1'b0;
    logic        repeat_en = 1'b0, loop_count_en = 1'b0, loop_count_clr = 1'b0;
    logic [9:0]  loop_target = '0;
    logic [8:0]  entry_mark = '0;
    logic [7:0]  tick_div = 8'd1;
    logic        rest_level = 1'b1, rest_drive = 1'b1;
    logic [15:0] mem_rdata = '0;
    logic        mem_ren;
    logic [3:0]  mem_raddr;
    logic        pulse_out, pulse_oe;
    logic [2:0]  seq_state;
    logic        done_evt, mark_evt, loops_evt;
    logic [15:0] mem [16];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) if (mem_ren) mem_rdata <= mem[mem_raddr];

    pulse_seq dut_i (
        .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
        .repeat_en(repeat_en), .loop_count_en(loop_count_en), .loop_target(loop_target),
        .loop_count_clr(loop_count_clr), .entry_mark(entry_mark), .tick_div(tick_div),
        .rest_level(rest_level), .rest_drive(rest_drive), .mem_rdata(mem_rdata),
        .mem_ren(mem_ren), .mem_raddr(mem_raddr), .pulse_out(pulse_out), .pulse_oe(pulse_oe),
        .seq_state(seq_state), .done_evt(done_evt), .mark_evt(mark_evt), .loops_evt(loops_evt)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic load(input int d0, input int d1, input int d2);
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[0] = {1'b1, 15'(d0)};
        mem[1] = {1'b0, 15'(d1)};
        mem[2] = {1'b1, 15'(d2)};
    endtask

    // Expected edge counts (after the start edge) for end and mark events.
    function automatic void expect_run(input int dv, input int d0, input int d1, input int d2,
                                       input int mk, input int rep, input int tgt,
                                       output int k_end, output int k_mark);
        int d[3];
        int eff, n, passes, t, sent;
        d[0] = d0; d[1] = d1; d[2] = d2;
        eff = (dv <= 1) ? 1 : dv;
        n = 0;
        while (n < 3 && d[n] != 0) n++;
        passes = rep ? tgt : 1;
        t = 0; sent = 0; k_mark = 0;
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < n; i++) begin
                t += 2 + d[i] * eff;
                sent++;
                if (mk != 0 && sent == mk) k_mark = t;
            end
            t += 2;
        end
        k_end = t;
    endfunction

    // kind: 0 none, 1 start, 2 loop counter clear, 3 stop; poked for edge pk only.
    task automatic run(input int pk, input int kind, input int maxk,
                       output int k_end, output int k_mark, output int k_loop, output int rd0);
        int k;
        bit fin;
        k_end = 0; k_mark = 0; k_loop = 0; rd0 = 0; k = 0; fin = 0;
        @(negedge clk); run_start = 1'b1;
        @(posedge clk);
        while (!fin && k <= maxk) begin
            @(negedge clk);
            if (mem_ren && mem_raddr == 4'd0) rd0++;
            if (mark_evt && k_mark == 0) k_mark = k;
            if (loops_evt) k_loop = k;
            if (done_evt) begin k_end = k; fin = 1; end
            run_start      = (kind == 1 && k == pk - 1);
            loop_count_clr = (kind == 2 && k == pk - 1);
            run_stop       = (kind == 3 && k == pk - 1);
            if (!fin) begin @(posedge clk); k++; end
        end
        run_start = 1'b0; loop_count_clr = 1'b0; run_stop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ke, km, kl, r0, ee, em;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(seq_state == 3'd0, "R1 state", seq_state, 0);
        check(!done_evt && !mark_evt && !loops_evt && !mem_ren, "R1 events", done_evt, 0);
        check(pulse_out == 1'b1 && pulse_oe == 1'b1, "R1 rest output", pulse_out, 1);
        // R11 idle output follows rest inputs
        rest_level = 1'b0; rest_drive = 1'b0; #1;
        check(pulse_out == 1'b0, "R11 level", pulse_out, 0);
        check(pulse_oe == 1'b0, "R11 drive", pulse_oe, 0);

        // R2 state sequence and send level
        load(3, 0, 0); tick_div = 8'd1;
        @(negedge clk); run_start = 1'b1;
        @(posedge clk); @(negedge clk); run_start = 1'b0;
        check(seq_state == 3'd1 && mem_ren && mem_raddr == 4'd0, "R2 read", seq_state, 1);
        @(negedge clk);
        check(seq_state == 3'd2, "R2 capture", seq_state, 2);
        @(negedge clk);
        check(seq_state == 3'd3 && pulse_out && pulse_oe, "R2 send", seq_state, 3);
        repeat (10) @(negedge clk);
        check(seq_state == 3'd0, "R2 back idle", seq_state, 0);

        // Table walk: R2, R3, R4, R6, R8
        for (int r = 0; r < NROWS; r++) begin
            load(VEC[r][1], VEC[r][2], VEC[r][3]);
            tick_div = 8'(VEC[r][0]);
            entry_mark = 9'(VEC[r][4]);
            repeat_en = VEC[r][5][0];
            loop_count_en = 1'b1;
            loop_target = 10'(VEC[r][6]);
            expect_run(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], VEC[r][5], VEC[r][6], ee, em);
            run(0, 0, 2000, ke, km, kl, r0);
            check(ke == ee, "R2,R3,R4 end edge", ke, ee);
            check(km == em, "R8 mark edge", km, em);
            check(kl == (VEC[r][5] != 0 ? ee : 0), "R6 loop event", kl, VEC[r][5] != 0 ? ee : 0);
            @(negedge clk);
        end

        // R5 repeat without counting, then R9 stop
        load(2, 0, 0); tick_div = 8'd1; entry_mark = '0;
        repeat_en = 1'b1; loop_count_en = 1'b0; loop_target = 10'd1;
        run(40, 3, 45, ke, km, kl, r0);
        check(ke == 0, "R5 no end", ke, 0);
        check(r0 == 7, "R5 restarts at address 0", r0, 7);
        check(seq_state == 3'd0, "R9 idle after stop", seq_state, 0);

        // R7 pass counter clear mid-run
        loop_count_en = 1'b1; loop_target = 10'd2;
        run(8, 2, 100, ke, km, kl, r0);
        check(ke == 18, "R7 end after clear", ke, 18);

        // R10 start while busy ignored
        load(3, 0, 0); repeat_en = 1'b0;
        run(3, 1, 100, ke, km, kl, r0);
        check(ke == 7, "R10 timing unchanged", ke, 7);
        repeat (5) @(negedge clk);
        check(seq_state == 3'd0, "R10 no second run", seq_state, 0);

        // R9 stop at the terminator decode edge wins
        load(2, 0, 0);
        run(6, 3, 20, ke, km, kl, r0);
        check(ke == 0, "R9 stop beats end", ke, 0);
        check(seq_state == 3'd0, "R9 idle", seq_state, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule